// File: doc/BRIEF.md
# PCM Audio Port Framer

A full-duplex serial port for an 8 kHz telephony voice path. Every frame it sends one sample and receives one sample. The serial side has four lines: a bit clock, a frame sync, serial data in and serial data out. The parallel side moves samples through a valid/ready handshake in each direction. Samples are 16-bit linear or 8-bit companded codes. Companded codes pass through unchanged.

As master, the port divides the system clock down to a bit clock and derives the frame sync from it. The bit clock runs at one of two rates, giving 256 or 16 bit slots per frame. The sync is high for the first half of the frame and low for the second half. As slave, it follows an external high-rate clock and sync, taken into the system clock domain through synchronizers. An external sync rising edge that arrives out of turn re-aligns the slot counter. Configuration is static and changes only while reset is held.

Top module: `pcm_framer`

## Requirements
- R1: During and after synchronous reset: `pcm_clk_o`, `pcm_sync_o`, `pcm_dout`, `rx_valid` and `rx_overrun` are 0, and `tx_ready` is 1.
- R2: In master mode, `cfg_fast`=1 gives a bit clock period of 2*DIV_FAST system cycles and 256 rising bit-clock edges per frame. `cfg_fast`=0 gives 2*DIV_SLOW cycles and 16 edges per frame.
- R3: In master mode, `pcm_sync_o` is high for the first half of the slots of each frame and low for the second half. It changes only together with a rising bit-clock edge.
- R4: Serial output is MSB first, starting in slot 0, the slot that begins where sync rises. `pcm_dout` changes only at a rising bit-clock edge. `pcm_din` is sampled at the falling edge of each slot.
- R5: `cfg_wide`=1 carries 16 bits in slots 0..15. `cfg_wide`=0 carries `tx_data[7:0]` in slots 0..7 and returns `rx_data` with bits 15..8 equal to 0. In both widths, `pcm_dout` is 0 in every slot past the sample.
- R6: `tx_ready` is high while the transmit holding register is free. An accepted sample drops `tx_ready` until the next frame start, which consumes it.
- R7: If no new transmit sample was accepted before a frame start, the previous sample is sent again.
- R8: Exactly one received sample is presented per frame, after its last bit. `rx_valid` stays high until `rx_ready` takes it.
- R9: A new received sample completing while `rx_valid` is still high sets `rx_overrun`, which stays set until reset.
- R10: In slave mode (`cfg_master`=0), the port follows `pcm_clk_i`/`pcm_sync_i` with 256 slots per frame whatever `cfg_fast` is, and holds `pcm_clk_o` and `pcm_sync_o` at 0.
- R11: In slave mode, a rising edge of the external sync at any slot restarts the frame at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master (generate clock/sync), 0 = slave |
| cfg_fast | input | 1 | Master bit clock rate: 1 = 256 slots, 0 = 16 slots per frame |
| cfg_wide | input | 1 | 1 = 16-bit linear, 0 = 8-bit companded code |
| pcm_clk_i | input | 1 | External bit clock (slave) |
| pcm_sync_i | input | 1 | External frame sync (slave) |
| pcm_din | input | 1 | Serial receive data |
| pcm_clk_o | output | 1 | Generated bit clock (master) |
| pcm_sync_o | output | 1 | Generated frame sync (master) |
| pcm_dout | output | 1 | Serial transmit data |
| tx_data | input | 16 | Transmit sample |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit holding register free |
| rx_data | output | 16 | Received sample |
| rx_valid | output | 1 | Received sample available |
| rx_ready | input | 1 | Received sample taken |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
In master mode, serial out is looped back to serial in. A sequence of distinct, asymmetric samples is sent so that bit order, MSB placement and frame-to-frame repetition can each be told apart. An all-ones sample shows the zero padding past the sample width and separates the narrow lane from the wide one. This loopback runs at both clock rates. At each rate, clock period, sync duty and edges per frame are counted. Withholding receive ready for two frames separates a held sample from an overrun. In slave mode, the bench drives a full frame, then a short frame, then a full frame with the fast-rate select cleared. This shows the fixed 256-slot frame and the re-alignment on an early sync: an unaligned counter would either drop the sample or deliver extra ones.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int SLOTS_FAST = 256;
    localparam int SLOTS_SLOW = 16;
    localparam int SLOT_W     = $clog2(SLOTS_FAST);
    localparam int SAMPLE_W   = 16;
    localparam int NARROW_W   = 8;
    localparam int BIT_IDX_W  = $clog2(SAMPLE_W);

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [SAMPLE_W-1:0]  sample_t;
    typedef logic [BIT_IDX_W:0]   width_t;

    // Per-cycle timing strobes shared by the slot timer and the data lane
    typedef struct packed {
        logic  rise;         // bit clock rises at this edge
        logic  fall;         // bit clock falls at this edge
        logic  frame_start;  // the rise at this edge opens slot 0
        slot_t slot;         // slot currently in progress
        slot_t slot_nxt;     // slot that the coming rise opens
    } pcm_tick_t;

    function automatic slot_t last_slot(input logic master, input logic fast);
        return (!master || fast) ? slot_t'(SLOTS_FAST - 1) : slot_t'(SLOTS_SLOW - 1);
    endfunction

    function automatic width_t lane_width(input logic wide);
        return wide ? width_t'(SAMPLE_W) : width_t'(NARROW_W);
    endfunction

endpackage

// File: rtl/pcm_bitclk_gen.sv
module pcm_bitclk_gen #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast,
    output logic bclk,
    output logic rise,
    output logic fall
);
    localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          wrap;

    assign lim  = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    assign wrap = en && (cnt >= lim);
    assign rise = wrap && !bclk;
    assign fall = wrap && bclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            bclk <= !bclk;
        end else begin
            cnt  <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pcm_ext_sync.sv
module pcm_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_sync,
    input  logic ext_din,
    output logic sync_s,
    output logic din_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] clk_pipe;
    logic [STAGES-1:0] sync_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              clk_d;
    logic              clk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_pipe  <= '0;
            sync_pipe <= '0;
            din_pipe  <= '0;
            clk_d     <= 1'b0;
        end else begin
            clk_pipe  <= {clk_pipe[STAGES-2:0],  ext_clk};
            sync_pipe <= {sync_pipe[STAGES-2:0], ext_sync};
            din_pipe  <= {din_pipe[STAGES-2:0],  ext_din};
            clk_d     <= clk_s;
        end
    end

    assign clk_s  = clk_pipe[STAGES-1];
    assign sync_s = sync_pipe[STAGES-1];
    assign din_s  = din_pipe[STAGES-1];
    assign rise   = clk_s && !clk_d;
    assign fall   = !clk_s && clk_d;
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      master,
    input  logic      fast,
    input  logic      m_rise,
    input  logic      m_fall,
    input  logic      s_rise,
    input  logic      s_fall,
    input  logic      s_sync,
    output pcm_tick_t tick,
    output logic      sync_o
);
    slot_t slot;
    slot_t slot_nxt;
    slot_t last;
    logic  rise;
    logic  sync_prev;
    logic  realign;

    assign rise     = master ? m_rise : s_rise;
    assign last     = last_slot(master, fast);
    assign realign  = !master && s_sync && !sync_prev;
    assign slot_nxt = (realign || slot >= last) ? '0 : slot + slot_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '1;
            sync_prev <= 1'b0;
            sync_o    <= 1'b0;
        end else if (rise) begin
            slot      <= slot_nxt;
            sync_prev <= s_sync;
            sync_o    <= master && (slot_nxt <= (last >> 1));
        end
    end

    always_comb begin
        tick.rise        = rise;
        tick.fall        = master ? m_fall : s_fall;
        tick.frame_start = rise && (slot_nxt == '0);
        tick.slot        = slot;
        tick.slot_nxt    = slot_nxt;
    end
endmodule

// File: rtl/pcm_lane.sv
module pcm_lane
    import pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wide,
    input  pcm_tick_t tick,
    input  logic      din,
    input  sample_t   tx_data,
    input  logic      tx_valid,
    output logic      tx_ready,
    output logic      dout,
    output sample_t   rx_data,
    output logic      rx_valid,
    input  logic      rx_ready,
    output logic      rx_overrun
);
    width_t                 w;
    slot_t                  w_slot;
    logic                   lane_nxt;
    logic [BIT_IDX_W-1:0]   tx_idx;
    sample_t                tx_hold;
    sample_t                tx_cur;
    sample_t                tx_src;
    logic                   tx_fresh;
    logic                   accept;
    logic [SAMPLE_W-2:0]    rx_sh;
    sample_t                rx_word;
    sample_t                rx_out;
    logic                   rx_in_lane;
    logic                   rx_done;

    assign w        = lane_width(wide);
    assign w_slot   = slot_t'(w);
    assign lane_nxt = tick.slot_nxt < w_slot;
    assign tx_idx   = BIT_IDX_W'(w - width_t'(1)) - tick.slot_nxt[BIT_IDX_W-1:0];
    assign tx_src   = tick.frame_start ? tx_hold : tx_cur;

    assign tx_ready = !tx_fresh;
    assign accept   = tx_valid && !tx_fresh;

    // transmit: hold register, frame copy, bit launch on rise
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_hold  <= '0;
            tx_cur   <= '0;
            tx_fresh <= 1'b0;
            dout     <= 1'b0;
        end else begin
            if (accept)
                tx_hold <= tx_data;
            if (accept)
                tx_fresh <= 1'b1;
            else if (tick.frame_start)
                tx_fresh <= 1'b0;
            if (tick.frame_start)
                tx_cur <= tx_hold;
            if (tick.rise)
                dout <= lane_nxt ? tx_src[tx_idx] : 1'b0;
        end
    end

    assign rx_in_lane = tick.fall && (tick.slot < w_slot);
    assign rx_done    = rx_in_lane && (tick.slot == w_slot - slot_t'(1));
    assign rx_word    = {rx_sh, din};
    assign rx_out     = wide ? rx_word : (rx_word & sample_t'({NARROW_W{1'b1}}));

    // receive: shift on fall, present once per frame
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh      <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (rx_in_lane)
                rx_sh <= rx_word[SAMPLE_W-2:0];
            if (rx_done) begin
                rx_data  <= rx_out;
                rx_valid <= 1'b1;
                if (rx_valid && !rx_ready)
                    rx_overrun <= 1'b1;
            end else if (rx_valid && rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
    import pcm_pkg::*;
#(
    parameter int DIV_FAST    = 4,
    parameter int DIV_SLOW    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_master,
    input  logic                cfg_fast,
    input  logic                cfg_wide,
    input  logic                pcm_clk_i,
    input  logic                pcm_sync_i,
    input  logic                pcm_din,
    output logic                pcm_clk_o,
    output logic                pcm_sync_o,
    output logic                pcm_dout,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic                rx_overrun
);
    logic      m_rise, m_fall;
    logic      s_rise, s_fall, s_sync, s_din;
    pcm_tick_t tick;

    pcm_bitclk_gen #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_master),
        .fast (cfg_fast),
        .bclk (pcm_clk_o),
        .rise (m_rise),
        .fall (m_fall)
    );

    pcm_ext_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ext_clk  (pcm_clk_i),
        .ext_sync (pcm_sync_i),
        .ext_din  (pcm_din),
        .sync_s   (s_sync),
        .din_s    (s_din),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    pcm_slot_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .master (cfg_master),
        .fast   (cfg_fast),
        .m_rise (m_rise),
        .m_fall (m_fall),
        .s_rise (s_rise),
        .s_fall (s_fall),
        .s_sync (s_sync),
        .tick   (tick),
        .sync_o (pcm_sync_o)
    );

    pcm_lane u_lane (
        .clk        (clk),
        .rst        (rst),
        .wide       (cfg_wide),
        .tick       (tick),
        .din        (s_din),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .dout       (pcm_dout),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_overrun (rx_overrun)
    );
endmodule

// File: rtl/pcm_framer_chk.sv
module pcm_framer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_master,
    input logic pcm_clk_o,
    input logic pcm_sync_o,
    input logic pcm_dout,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_overrun
);
    a_r10_slave_outputs_low: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> (!pcm_clk_o && !pcm_sync_o));

    a_r3_sync_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !$stable(pcm_sync_o)) |-> $rose(pcm_clk_o));

    a_r4_dout_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !$rose(pcm_clk_o)) |-> $stable(pcm_dout));

    a_r6_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r8_rx_held: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_valid && !rx_ready));
endmodule

bind pcm_framer pcm_framer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .pcm_clk_o  (pcm_clk_o),
    .pcm_sync_o (pcm_sync_o),
    .pcm_dout   (pcm_dout),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun)
);

// File: tb/test_pcm_framer.sv
module test_pcm_framer;
    localparam int DIV_FAST = 4;
    localparam int DIV_SLOW = 64;
    localparam int SLV_HALF = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        cfg_master = 1'b1, cfg_fast = 1'b1, cfg_wide = 1'b1;
    logic        slv_clk = 1'b0, slv_sync = 1'b0, slv_din = 1'b0;
    logic        loop_en = 1'b1;
    logic        pcm_din;
    logic        pcm_clk_o, pcm_sync_o, pcm_dout;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        rx_accept = 1'b1;
    logic        rx_overrun;

    int          checks = 0;
    int          errors = 0;
    bit          strict = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] prev_tx = '0;

    assign pcm_din = loop_en ? pcm_dout : slv_din;

    pcm_framer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_pcm_framer (
        .clk(clk), .rst(rst),
        .cfg_master(cfg_master), .cfg_fast(cfg_fast), .cfg_wide(cfg_wide),
        .pcm_clk_i(slv_clk), .pcm_sync_i(slv_sync), .pcm_din(pcm_din),
        .pcm_clk_o(pcm_clk_o), .pcm_sync_o(pcm_sync_o), .pcm_dout(pcm_dout),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_accept),
        .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard at each received-sample handshake
    always @(negedge clk) begin
        if (!rst && rx_valid && rx_accept) begin
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R4/R5/R7/R8", "rx sample", rx_data, e);
            end else if (strict) begin
                chk("R10/R11", "unexpected rx sample", rx_data, 17'h10000);
            end
        end
    end

    function automatic logic [15:0] lane_map(input logic [15:0] v, input logic wide);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic wait_sync_rise();
        logic p;
        p = pcm_sync_o;
        @(negedge clk);
        while (!(pcm_sync_o && !p)) begin
            p = pcm_sync_o;
            @(negedge clk);
        end
    endtask

    task automatic wait_clk_rise();
        logic p;
        p = pcm_clk_o;
        @(negedge clk);
        while (!(pcm_clk_o && !p)) begin
            p = pcm_clk_o;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic m, input logic f, input logic wd);
        cfg_master = m; cfg_fast = f; cfg_wide = wd;
        rst = 1'b1;
        prev_tx = '0;
        repeat (4) @(negedge clk);
        chk("R1", "clk_o in reset", pcm_clk_o, 0);
        chk("R1", "dout in reset", pcm_dout, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "sync_o after reset", pcm_sync_o, 0);
        chk("R1", "rx_valid after reset", rx_valid, 0);
        chk("R1", "overrun after reset", rx_overrun, 0);
        chk("R1", "tx_ready after reset", tx_ready, 1);
    endtask

    task automatic tx_write(input logic [15:0] v);
        tx_data = v;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R6", "tx_ready after accept", tx_ready, 0);
    endtask

    // Each frame carries a known sample: the old one (repeat) then the new one
    task automatic send(input logic [15:0] v);
        wait_sync_rise();
        chk("R6", "tx_ready after frame start", tx_ready, 1);
        exp_q.push_back(lane_map(prev_tx, cfg_wide));
        tx_write(v);
        wait_sync_rise();
        exp_q.push_back(lane_map(v, cfg_wide));
        prev_tx = v;
    endtask

    task automatic measure(input int div, input int nslots, input int w);
        int n, hi, lo, rises, bad;
        logic pc;
        wait_clk_rise();
        n = 0;
        pc = pcm_clk_o;
        @(negedge clk); n++;
        while (!(pcm_clk_o && !pc)) begin
            pc = pcm_clk_o;
            @(negedge clk); n++;
        end
        chk("R2", "bit clock period", n, 2 * div);
        wait_sync_rise();
        hi = 0; lo = 0; rises = 0; bad = 0; pc = 1'b0;
        while (pcm_sync_o) begin
            if (pcm_clk_o && !pc) rises++;
            if (rises > w && pcm_dout) bad++;
            pc = pcm_clk_o;
            hi++;
            @(negedge clk);
        end
        while (!pcm_sync_o) begin
            if (pcm_clk_o && !pc) rises++;
            if (rises > w && pcm_dout) bad++;
            pc = pcm_clk_o;
            lo++;
            @(negedge clk);
        end
        chk("R2", "bit clocks per frame", rises, nslots);
        chk("R3", "sync high cycles", hi, nslots * div);
        chk("R3", "sync low cycles", lo, nslots * div);
        chk("R5", "dout high past sample", bad, 0);
    endtask

    task automatic slv_frame(input int nslots, input logic [15:0] word, output logic [15:0] got);
        got = '0;
        for (int s = 0; s < nslots; s++) begin
            slv_clk = 1'b1;
            slv_sync = (s < nslots / 2);
            slv_din = (s < 16) ? word[15 - s] : 1'b0;
            repeat (SLV_HALF) @(negedge clk);
            if (s < 16) got[15 - s] = pcm_dout;
            slv_clk = 1'b0;
            repeat (SLV_HALF) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R1..): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] got;

        // Master, fast rate, 16-bit, loopback
        do_reset(1'b1, 1'b1, 1'b1);
        send(16'hA5C3);
        send(16'h0F1E);
        send(16'h8001);
        send(16'hFFFF);
        measure(DIV_FAST, 256, 16);
        wait_sync_rise();
        chk("R8", "all fast samples delivered", exp_q.size(), 0);

        // Overrun: withhold ready across two frames
        rx_accept = 1'b0;
        wait_sync_rise();
        chk("R8", "sample held without ready", rx_valid, 1);
        chk("R9", "no overrun after one frame", rx_overrun, 0);
        wait_sync_rise();
        chk("R9", "overrun after second frame", rx_overrun, 1);
        rx_accept = 1'b1;
        wait_sync_rise();
        chk("R9", "overrun sticky", rx_overrun, 1);

        // Master, slow rate, 16-bit
        do_reset(1'b1, 1'b0, 1'b1);
        send(16'h3C96);
        send(16'hFFFF);
        measure(DIV_SLOW, 16, 16);
        wait_sync_rise();
        chk("R8", "all slow samples delivered", exp_q.size(), 0);

        // Master, slow rate, 8-bit
        do_reset(1'b1, 1'b0, 1'b0);
        send(16'h12B7);
        send(16'h5D4A);
        send(16'hFFFF);
        measure(DIV_SLOW, 16, 8);
        wait_sync_rise();
        chk("R5", "all narrow samples delivered", exp_q.size(), 0);

        // Slave, fast-rate select cleared, 16-bit
        loop_en = 1'b0;
        do_reset(1'b0, 1'b0, 1'b1);
        strict = 1'b1;
        tx_write(16'hC3A5);
        exp_q.push_back(16'h9E27);
        slv_frame(256, 16'h9E27, got);
        chk("R10", "slave dout full frame", got, 16'hC3A5);
        chk("R10", "slave clk_o held low", pcm_clk_o, 0);
        chk("R10", "slave sync_o held low", pcm_sync_o, 0);
        exp_q.push_back(16'h4B71);
        slv_frame(64, 16'h4B71, got);
        chk("R7", "slave repeats sample", got, 16'hC3A5);
        tx_write(16'h5A3C);
        exp_q.push_back(16'hD00B);
        slv_frame(256, 16'hD00B, got);
        chk("R11", "dout after early sync", got, 16'h5A3C);
        repeat (20) @(negedge clk);
        chk("R11", "slave samples delivered", exp_q.size(), 0);
        strict = 1'b0;

        finish_run();
    end
endmodule